// File: doc/BRIEF.md
# Host controller command and status register

This block is one 32-bit word in the operational register space of a USB host controller. It sits at byte offset 08h. Software reaches it through a plain register port that carries a byte address, a write enable, write data and a combinational read path. Four low command bits are set by software and cleared only by hardware. A two-bit counter records scheduling overruns reported by the frame scheduler.

Bit 3 asks for a change of controller ownership. When software sets it, the block sends a one-cycle pulse to the interrupt status register, which sets the ownership-change status bit there. The bit stays set until control logic reports that the changeover is done. The four command bits also leave the block directly, so that the reset sequencer, the list processors and the ownership logic can see them.

Top module: `hc_cmd_status`

## Requirements
- R1: After reset, every bit of the register reads 0, `req_bits` is 0 and `oc_set` is low.
- R2: A write at offset 08h sets each of bits 3:0 whose write-data bit is 1. Bit 0 is the reset request, bit 1 is control list filled, bit 2 is bulk list filled and bit 3 is the ownership request.
- R3: A write of 0 to any of bits 3:0 has no effect. Without a clear input, none of these bits ever drops.
- R4: Each command bit is cleared by its own input: `clr_reset` clears bit 0, `clr_ctrl` clears bit 1, `clr_bulk` clears bit 2 and `owner_done` clears bit 3.
- R5: When a software write and a hardware clear target the same bit in the same cycle, the bit ends up 0.
- R6: Bits 17:16 hold a count that rises by one on every cycle in which `sched_overrun` is high. It wraps from 3 to 0, and it counts regardless of any write or any other input.
- R7: Software writes to bits 17:16 have no effect on the count.
- R8: `oc_set` is high for exactly one cycle, in the first cycle in which bit 3 reads 1. It stays low when software writes 1 to bit 3 while the bit is already set, and it stays low when that write is cancelled by `owner_done` in the same cycle.
- R9: All bits other than 3:0 and 17:16 read 0. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R10: `req_bits` always equals bits 3:0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address within the operational space |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| sched_overrun | input | 1 | Scheduling overrun event pulse |
| owner_done | input | 1 | Ownership changeover complete; clears bit 3 |
| clr_reset | input | 1 | Clears the reset request bit |
| clr_ctrl | input | 1 | Clears the control-list-filled bit |
| clr_bulk | input | 1 | Clears the bulk-list-filled bit |
| oc_set | output | 1 | One-cycle request to set the ownership-change status bit |
| req_bits | output | 4 | Current command bits 3:0 |

## Verification
The hardest situations to reach are collisions within a single cycle. In one, a write of all ones meets a clear pulse on the same bit. In another, an overrun pulse arrives together with a write that tries to load the count field. In the third, `owner_done` cancels the write that would have started an ownership request, and so no `oc_set` pulse should appear. The vector table drives these collisions in the same cycle and steps the counter through its wrap. Directed tests then watch `oc_set` cycle by cycle to confirm that the pulse does not repeat when the request bit is written again.

// File: rtl/hc_cmd_status.sv
module hc_cmd_status #(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08,
  parameter int               DATA_W     = 32,
  parameter int               NCMD       = 4,
  parameter int               CNT_W      = 2,
  parameter int               CNT_LSB    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sched_overrun,
  input  logic              owner_done,
  input  logic              clr_reset,
  input  logic              clr_ctrl,
  input  logic              clr_bulk,
  output logic              oc_set,
  output logic [NCMD-1:0]   req_bits
);
  localparam int OWN_BIT = NCMD - 1;
  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

  logic [NCMD-1:0]  cmd_q, cmd_nxt, hw_clr, sw_set;
  logic [CNT_W-1:0] soc_q;
  logic             oc_q;
  logic             sel;

  assign sel     = (addr == REG_OFFSET);
  assign hw_clr  = {owner_done, clr_bulk, clr_ctrl, clr_reset};
  assign sw_set  = (wr_en && sel) ? wr_data[NCMD-1:0] : '0;
  assign cmd_nxt = (cmd_q | sw_set) & ~hw_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      soc_q <= '0;
      oc_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_nxt;
      oc_q  <= cmd_nxt[OWN_BIT] & ~cmd_q[OWN_BIT];
      if (sched_overrun) soc_q <= soc_q + 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel) begin
      rd_data[NCMD-1:0]       = cmd_q;
      rd_data[CNT_MSB:CNT_LSB] = soc_q;
    end
  end

  assign oc_set   = oc_q;
  assign req_bits = cmd_q;
endmodule

module hc_cmd_status_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCMD   = 4,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sched_overrun,
  input logic              owner_done,
  input logic              clr_reset,
  input logic              clr_ctrl,
  input logic              clr_bulk,
  input logic              oc_set,
  input logic [NCMD-1:0]   req_bits,
  input logic [CNT_W-1:0]  soc
);
  p_soc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sched_overrun |=> soc == CNT_W'($past(soc) + 1'b1));
  p_soc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_overrun |=> $stable(soc));
  p_oc_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oc_set |-> req_bits[NCMD-1]);
  p_oc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oc_set |=> !oc_set);
  p_owner_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    owner_done |=> !req_bits[NCMD-1]);
  p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(owner_done || clr_bulk || clr_ctrl || clr_reset)
      |=> (($past(req_bits) & ~req_bits) == '0));
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~32'h0003_000F) == '0);
  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 8'h08) |-> rd_data == '0);
endmodule

bind hc_cmd_status hc_cmd_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCMD(NCMD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data),
  .sched_overrun(sched_overrun), .owner_done(owner_done),
  .clr_reset(clr_reset), .clr_ctrl(clr_ctrl), .clr_bulk(clr_bulk),
  .oc_set(oc_set), .req_bits(req_bits), .soc(soc_q)
);

// File: tb/sim_hc_cmd_status.sv
module sim_hc_cmd_status;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  clr;
    logic        ovf;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b1, 8'h08, 32'h0000_0001, 4'h0, 1'b0, 32'h0000_0001},
    '{1'b1, 8'h08, 32'h0000_0000, 4'h0, 1'b0, 32'h0000_0001},
    '{1'b1, 8'h08, 32'h0000_0006, 4'h0, 1'b0, 32'h0000_0007},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h1, 1'b0, 32'h0000_0006},
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 4'h2, 1'b0, 32'h0000_000D},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h0, 1'b1, 32'h0001_000D},
    '{1'b1, 8'h08, 32'h0003_0000, 4'h0, 1'b1, 32'h0002_000D},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h0, 1'b1, 32'h0003_000D},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h0, 1'b1, 32'h0000_000D},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h8, 1'b0, 32'h0000_0005},
    '{1'b1, 8'h0C, 32'h0000_000F, 4'h0, 1'b0, 32'h0000_0005},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h4, 1'b0, 32'h0000_0001},
    '{1'b0, 8'h08, 32'h0000_0000, 4'h1, 1'b0, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = 8'h08;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic sched_overrun = 1'b0, owner_done = 1'b0;
  logic clr_reset = 1'b0, clr_ctrl = 1'b0, clr_bulk = 1'b0;
  logic oc_set;
  logic [3:0] req_bits;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_cmd_status u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sched_overrun(sched_overrun), .owner_done(owner_done),
    .clr_reset(clr_reset), .clr_ctrl(clr_ctrl), .clr_bulk(clr_bulk),
    .oc_set(oc_set), .req_bits(req_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = '0; addr = 8'h08; sched_overrun = 0;
    owner_done = 0; clr_reset = 0; clr_ctrl = 0; clr_bulk = 0;
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    wr_en = v.wr; addr = v.addr; wr_data = v.data; sched_overrun = v.ovf;
    {owner_done, clr_bulk, clr_ctrl, clr_reset} = v.clr;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset read", rd_data, 32'h0);
    check("R1 reset req_bits", {28'h0, req_bits}, 32'h0);
    check("R1 reset oc_set", {31'h0, oc_set}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i]);
      check($sformatf("R2-table vector %0d (R3 R4 R5 R6 R7 R9)", i), rd_data, VECS[i].exp);
      check($sformatf("R10 vector %0d", i), {28'h0, req_bits}, {28'h0, VECS[i].exp[3:0]});
    end

    // R8: pulse on first cycle bit 3 reads 1
    @(negedge clk); wr_en = 1; wr_data = 32'h8;
    @(posedge clk); #1;
    check("R8 pulse present", {31'h0, oc_set}, 32'h1);
    check("R8 bit set", {28'h0, req_bits}, 32'h8);
    @(negedge clk); idle();
    @(posedge clk); #1;
    check("R8 pulse one cycle", {31'h0, oc_set}, 32'h0);
    // R8: rewrite while set gives no pulse
    @(negedge clk); wr_en = 1; wr_data = 32'h8;
    @(posedge clk); #1;
    check("R8 no repeat pulse", {31'h0, oc_set}, 32'h0);
    @(negedge clk); idle(); owner_done = 1;
    @(negedge clk); idle(); #1;
    check("R4 owner_done clears bit3", rd_data, 32'h0);
    // R5/R8: write cancelled by owner_done
    @(negedge clk); wr_en = 1; wr_data = 32'h8; owner_done = 1;
    @(posedge clk); #1;
    check("R8 no pulse when cancelled", {31'h0, oc_set}, 32'h0);
    check("R5 bit3 stays clear", rd_data, 32'h0);
    @(negedge clk); idle();
    // R9: read at other offset returns 0
    @(negedge clk); wr_en = 1; wr_data = 32'h7; sched_overrun = 1;
    @(negedge clk); idle(); addr = 8'h04; #1;
    check("R9 other offset reads 0", rd_data, 32'h0);
    addr = 8'h08; #1;
    check("R6 count after overrun", rd_data, 32'h0001_0007);
    // R1: reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    check("R1 reset mid-run", rd_data, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule